// File: doc/BRIEF.md
# Variable-length instruction prefetch queue

This block keeps a small ring of instruction bytes filled ahead of a decoder. It drives its own incrementing address onto a separate program-memory bus and stores each returned byte in an eight-entry circular buffer. Because instructions run from one to five bytes, the decoder cannot take a fixed amount each cycle. Instead it reads the occupancy count, looks at the next five bytes through a peek window, and consumes an instruction only once the count shows that every one of its bytes is present.

A two-state sequencer controls the fetching. In the address state it loads the fetch address from a start value: a reset vector after reset, or the program counter captured by the last restart. It clears the ring and then moves to the read state. In the read state, each enabled cycle in which the ring is not full stores one byte and advances the address. A single enable input gates all fetching. The enable is dropped while interrupts are serviced, while program memory is read as data, and while a debugger holds the bus. A restart input flushes the ring and returns the sequencer to the address state.

Program memory is assumed to have one cycle of latency. The byte stored at a clock edge belongs to the address that was on `pm_addr` during the cycle before that edge.

Top module: `ifq_top`

## Requirements
- R1: During and after reset, `avail` is 0, `full` is 0, `take_err` is 0 and `pm_addr` is 0. Nothing is fetched until `fetch_en` is high.
- R2: In the first enabled cycle of the address state, `pm_addr` is loaded with the start address: RESET_PC after reset, or the captured `pc_in` after a restart. The ring stays empty, with `avail` equal to 0.
- R3: In the read state, each cycle with `fetch_en` high and `full` low stores `pm_data`, which is the byte of the address then on `pm_addr`. In the same cycle `pm_addr` increases by 1 and `avail` increases by 1.
- R4: `full` is 1 exactly when `avail` is 8. While `full` is 1, no byte is stored and `pm_addr` holds its value.
- R5: While `fetch_en` is low, `pm_addr` never changes, and `avail` changes only through a consume.
- R6: For each k below min(`avail`,5), bits [8k+7:8k] of `peek` hold the byte fetched from the head address plus k. The head is the oldest byte not yet consumed. The window wraps across the end of the ring without a gap.
- R7: A consume is a request with `take_valid` high and `take_len` equal to N. When 1 ≤ N ≤ 5 and N ≤ `avail`, it removes N bytes: `avail` drops by N, the head moves forward N bytes modulo 8, and `full` clears.
- R8: When a byte is stored and a consume is accepted in the same cycle, `avail` changes by 1 − N.
- R9: A consume with N equal to 0, 6 or 7, or with N greater than `avail`, is ignored: `avail` and the head are unchanged by it. `take_err` is then 1 for exactly the following cycle.
- R10: `restart` takes priority over fetching and consuming. In the next cycle `avail` is 0 and `full` is 0, and no error is flagged for a consume that was presented with the restart. `pc_in` is captured as the next start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Enables fetching |
| restart | input | 1 | Flush the ring and restart at `pc_in` |
| pc_in | input | ADDR_W (16) | Restart address |
| pm_addr | output | ADDR_W (16) | Program-memory address |
| pm_data | input | 8 | Byte returned for the address on `pm_addr` |
| avail | output | 4 | Bytes ready for the decoder, 0 to 8 |
| full | output | 1 | Ring holds 8 bytes |
| peek | output | 40 | Next five bytes; the head byte is in bits [7:0] |
| take_valid | input | 1 | Consume request |
| take_len | input | 3 | Number of bytes to consume |
| take_err | output | 1 | Previous consume was rejected |

## Verification
The bench fills the ring until it is full and holds it there. A design that let a write through at full would overwrite the head byte and move `pm_addr` on to a byte it never stored. The bench then consumes while the ring is full, and also consumes and fetches in the same cycle. A design that got these wrong would leave `full` stuck, or would apply only one of the two count changes. Repeated consumes carry the head and the write position past entry seven, so a design that mishandles the wrap would put the wrong byte on `peek`. The bench also presents over-length, zero-length and too-early consumes, and a restart together with a consume. A faulty design would move the head on a rejected request, miss the one-cycle error, or fetch from the old address after a restart.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

  typedef enum logic {
    FS_ADDR = 1'b0,
    FS_READ = 1'b1
  } fetch_state_t;

  // position p moved forward by n entries in a ring of the given depth
  function automatic int ring_add(input int p, input int n, input int depth);
    return (p + n) % depth;
  endfunction

  // occupancy after one cycle of optional write and a take of n bytes
  function automatic int occ_next(input int occ, input bit wr, input int taken);
    return occ + (wr ? 1 : 0) - taken;
  endfunction

  // a take request is legal when its length is 1..max and no more than held
  function automatic bit take_legal(input int len, input int occ, input int max_len);
    return (len >= 1) && (len <= max_len) && (len <= occ);
  endfunction

endpackage

// File: rtl/ifq_seq.sv
module ifq_seq
  import ifq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              restart,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              full,
  output logic [ADDR_W-1:0] pm_addr,
  output logic              wr_fire,
  output logic              flush
);

  fetch_state_t      state_q;
  logic [ADDR_W-1:0] start_q;
  logic              addr_go;

  assign addr_go = (state_q == FS_ADDR) && fetch_en && !restart;
  assign wr_fire = (state_q == FS_READ) && fetch_en && !full && !restart;
  assign flush   = restart || addr_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_ADDR;
      start_q <= RESET_PC;
      pm_addr <= '0;
    end else if (restart) begin
      state_q <= FS_ADDR;
      start_q <= pc_in;
    end else if (addr_go) begin
      state_q <= FS_READ;
      pm_addr <= start_q;
    end else if (wr_fire) begin
      pm_addr <= pm_addr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/ifq_store.sv
module ifq_store
  import ifq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int TAKE_MAX = 5,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_fire,
  input  logic [7:0]            pm_data,
  input  logic [PTR_W-1:0]      rd_ptr,
  output logic [8*TAKE_MAX-1:0] peek
);

  logic [7:0]       ring [DEPTH];
  logic [PTR_W-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
    end else if (wr_fire) begin
      wr_ptr <= PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      ring[wr_ptr] <= pm_data;
    end
  end

  for (genvar k = 0; k < TAKE_MAX; k++) begin : g_peek
    logic [PTR_W-1:0] slot;
    assign slot = PTR_W'(ring_add(int'(rd_ptr), k, DEPTH));
    assign peek[8*k +: 8] = ring[slot];
  end

endmodule

// File: rtl/ifq_track.sv
module ifq_track
  import ifq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int TAKE_MAX = 5,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int LEN_W   = $clog2(TAKE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             restart,
  input  logic             wr_fire,
  input  logic             take_valid,
  input  logic [LEN_W-1:0] take_len,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] avail,
  output logic             full,
  output logic             take_err,
  output logic             take_fire,
  output logic             take_bad
);

  logic len_ok;
  int   taken;

  assign len_ok    = take_legal(int'(take_len), int'(avail), TAKE_MAX);
  assign take_fire = take_valid && !restart && len_ok;
  assign take_bad  = take_valid && !restart && !len_ok;
  assign taken     = take_fire ? int'(take_len) : 0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      avail  <= '0;
      full   <= 1'b0;
    end else begin
      avail <= CNT_W'(occ_next(int'(avail), wr_fire, taken));
      if (take_fire) begin
        rd_ptr <= PTR_W'(ring_add(int'(rd_ptr), taken, DEPTH));
        full   <= 1'b0;
      end else if (wr_fire && (int'(avail) == DEPTH - 1)) begin
        full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_err <= 1'b0;
    end else begin
      take_err <= take_bad;
    end
  end

endmodule

// File: rtl/ifq_top.sv
module ifq_top
  import ifq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DEPTH    = 8,
  parameter int TAKE_MAX = 5,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h0100,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int LEN_W   = $clog2(TAKE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_en,
  input  logic                  restart,
  input  logic [ADDR_W-1:0]     pc_in,
  output logic [ADDR_W-1:0]     pm_addr,
  input  logic [7:0]            pm_data,
  output logic [CNT_W-1:0]      avail,
  output logic                  full,
  output logic [8*TAKE_MAX-1:0] peek,
  input  logic                  take_valid,
  input  logic [LEN_W-1:0]      take_len,
  output logic                  take_err
);

  logic             wr_fire;
  logic             flush;
  logic             take_fire;
  logic             take_bad;
  logic [PTR_W-1:0] rd_ptr;

  ifq_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .restart(restart),
    .pc_in(pc_in), .full(full), .pm_addr(pm_addr),
    .wr_fire(wr_fire), .flush(flush)
  );

  ifq_store #(.DEPTH(DEPTH), .TAKE_MAX(TAKE_MAX)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_fire(wr_fire),
    .pm_data(pm_data), .rd_ptr(rd_ptr), .peek(peek)
  );

  ifq_track #(.DEPTH(DEPTH), .TAKE_MAX(TAKE_MAX)) u_track (
    .clk(clk), .rst_n(rst_n), .flush(flush), .restart(restart),
    .wr_fire(wr_fire), .take_valid(take_valid), .take_len(take_len),
    .rd_ptr(rd_ptr), .avail(avail), .full(full), .take_err(take_err),
    .take_fire(take_fire), .take_bad(take_bad)
  );

endmodule

// File: rtl/ifq_chk.sv
module ifq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int LEN_W  = 3,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_en,
  input logic              restart,
  input logic [LEN_W-1:0]  take_len,
  input logic [ADDR_W-1:0] pm_addr,
  input logic [CNT_W-1:0]  avail,
  input logic              full,
  input logic              wr_fire,
  input logic              take_fire,
  input logic              take_bad
);

  assert_full_matches_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full == (int'(avail) == DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(avail) <= DEPTH);

  assert_hold_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !restart) |=> $stable(pm_addr));

  assert_gate_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(pm_addr));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> pm_addr == $past(pm_addr) + ADDR_W'(1));

  assert_take_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && !wr_fire) |=> int'(avail) == int'($past(avail)) - int'($past(take_len)));

  assert_net_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && wr_fire) |=> int'(avail) == int'($past(avail)) + 1 - int'($past(take_len)));

  assert_bad_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bad && !restart) |=> int'(avail) == int'($past(avail)) + ($past(wr_fire) ? 1 : 0));

  assert_restart_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (avail == '0) && !full);

endmodule

bind ifq_top ifq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/ifq_top_tb.sv
`timescale 1ns/1ps
module ifq_top_tb;

  localparam logic [15:0] RST_PC = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_en = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] pm_addr;
  logic [7:0]  pm_data;
  logic [3:0]  avail;
  logic        full;
  logic [39:0] peek;
  logic        take_valid = 1'b0;
  logic [2:0]  take_len = '0;
  logic        take_err;

  int tests = 0;
  int fails = 0;

  // expected state built from the requirements
  bit          m_read;
  logic [15:0] m_start, m_addr, m_head;
  int          m_cnt;
  bit          m_err;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hC3;
  endfunction

  assign pm_data = mem_byte(pm_addr);

  ifq_top u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .restart(restart),
    .pc_in(pc_in), .pm_addr(pm_addr), .pm_data(pm_data), .avail(avail),
    .full(full), .peek(peek), .take_valid(take_valid), .take_len(take_len),
    .take_err(take_err)
  );

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  task automatic check_all(input string tag);
    bit bad = 0;
    tests++;
    if (int'(avail) != m_cnt || full != (m_cnt == 8) || pm_addr != m_addr || take_err != m_err)
      bad = 1;
    for (int k = 0; k < 5; k++)
      if (k < m_cnt && peek[8*k +: 8] != mem_byte(m_head + 16'(k))) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: avail=%0d full=%0b addr=%h err=%0b peek=%h | exp avail=%0d full=%0b addr=%h err=%0b head=%h",
               tag, avail, full, pm_addr, take_err, peek, m_cnt, m_cnt == 8, m_addr, m_err, m_head);
    end
  endtask

  // one clock: drive at negedge, update expectation, sample at next negedge
  task automatic cyc(input bit en, input bit rs, input logic [15:0] pc,
                     input bit tv, input int tl, input string tag);
    bit ok;
    fetch_en = en; restart = rs; pc_in = pc; take_valid = tv; take_len = 3'(tl);
    ok = tv && tl >= 1 && tl <= 5 && tl <= m_cnt;
    if (rs) begin
      m_read = 0; m_start = pc; m_cnt = 0; m_err = 0;
    end else if (!m_read) begin
      m_err = tv;
      if (en) begin
        m_addr = m_start; m_head = m_start; m_read = 1; m_cnt = 0;
      end
    end else begin
      bit wr = en && m_cnt < 8;
      m_err = tv && !ok;
      if (ok) begin m_head = m_head + 16'(tl); m_cnt -= tl; end
      if (wr) begin m_addr = m_addr + 16'd1; m_cnt++; end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic t_reset();
    rst_n = 0;
    m_read = 0; m_start = RST_PC; m_addr = 0; m_head = 0; m_cnt = 0; m_err = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_fill();
    cyc(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R4");
  endtask

  task automatic t_take_full();
    cyc(1, 0, 0, 1, 3, "R7");
    cyc(1, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_overlap();
    cyc(1, 0, 0, 1, 2, "R8");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 1, 1 + (i % 4), "R8");
    cyc(1, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_gate();
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 2, "R5");
    cyc(0, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_bad();
    cyc(0, 0, 0, 1, 6, "R9");
    cyc(0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, "R9");
    while (m_cnt > 2) cyc(0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 1, 4, "R9");
    cyc(1, 0, 0, 1, 7, "R9");
    cyc(1, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_restart();
    cyc(1, 1, 16'h2FFD, 1, 1, "R10");
    cyc(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 5, "R6");
    cyc(0, 1, 16'hFFFE, 0, 0, "R10");
    cyc(0, 0, 0, 1, 1, "R10");
    cyc(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, (i > 4), 2, "R8");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_take_full();
    t_overlap();
    t_gate();
    t_bad();
    t_restart();
    finish_up();
  end

endmodule